// File: doc/BRIEF.md
# 8-bit ALU with Flag Unit

This block is the arithmetic core of a classic 8-bit processor data path. A 4-bit operation select picks one of ten operations. The operations take the accumulator operand and a second operand and produce an 8-bit result. Arithmetic runs through a chain of 4-bit adders. The carry out of the low nibble becomes the auxiliary carry and also feeds the high nibble. Subtraction adds the ones' complement of the second operand.

Five status flags live in a register inside the block: sign, zero, auxiliary carry, parity and carry. The flags advance only when a write strobe is high. A separate load strobe replaces them with the contents of a byte, which is the pop path. The current flags are always available packed into a status byte for a push. They also feed a branch-condition evaluator that takes a 3-bit code. The instruction decoder around the block decides when to write the accumulator, and it uses the `acc_wr` hint to do so.

Top module: `alu8_flag_unit`

## Requirements
- R1: Operation codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 increment, 5 decrement, 6 AND, 7 XOR, 8 OR, 9 compare. Codes 10 to 15 are reserved and give result 0. For add, the result is acc+opnd mod 256, carry is bit 8 of the sum, and auxiliary carry is the carry out of acc[3:0]+opnd[3:0]. Add with carry also adds the carry flag.
- R2: Subtract computes acc+~opnd+1. Carry reports a borrow (set when acc<opnd unsigned). Auxiliary carry is the low-nibble carry of that sum, which is set when acc[3:0]>=opnd[3:0].
- R3: Subtract with borrow uses the inverted carry flag as carry-in, giving acc-opnd-CY. Carry reports the borrow, and auxiliary carry is set when acc[3:0] >= opnd[3:0]+CY.
- R4: For every operation 0 to 9, sign equals result bit 7, zero is set when the result is 0, and parity is set when the result has an even count of ones.
- R5: AND, XOR and OR clear carry and auxiliary carry.
- R6: Increment and decrement act on opnd and leave carry unchanged. Increment sets auxiliary carry when opnd[3:0]==15. Decrement sets it when opnd[3:0]!=0.
- R7: Compare produces the same result and flags as subtract, but `acc_wr` is low. `acc_wr` is high for codes 0 to 8 and low for compare and for the reserved codes.
- R8: `flags` is {sign, zero, aux, parity, carry} from bit 4 down to bit 0. A clock edge with `flag_ld` high loads the unpacked byte, and this takes priority over `flag_wr`. An edge with only `flag_wr` high loads `flags_nxt`. With neither strobe high, the flags hold.
- R9: Reserved codes leave `flags_nxt` equal to the current flags.
- R10: Reset clears all flags at once.
- R11: `status_byte` holds carry in bit 0, a constant 1 in bit 1, parity in bit 2, auxiliary carry in bit 4, zero in bit 6 and sign in bit 7. Bits 3 and 5 are 0.
- R12: Unpacking takes carry from bit 0, parity from bit 2, auxiliary carry from bit 4, zero from bit 6 and sign from bit 7. Bits 1, 3 and 5 are ignored.
- R13: `cond_true` tests the registered flags for `cond_code` as follows: 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity clear, 5 parity set, 6 sign clear, 7 sign set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation select |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand, and the target of increment and decrement |
| flag_wr | input | 1 | Write next flags at the clock edge |
| flag_ld | input | 1 | Load flags from `flag_byte_in` |
| flag_byte_in | input | 8 | Status byte to unpack |
| cond_code | input | 3 | Branch-condition select |
| result | output | 8 | Operation result |
| acc_wr | output | 1 | Result is meant for the accumulator |
| flags_nxt | output | 5 | Flags the current operation would produce |
| flags | output | 5 | Registered flags {S,Z,AC,P,CY} |
| status_byte | output | 8 | Packed flags |
| cond_true | output | 1 | Selected condition holds |

## Verification
Several rules are checked on every clock cycle: the strobe priority and hold behaviour of the flag register, the flags that a load puts in place, carry preservation on increment and decrement, the clearing of both carries by the logic operations, the zero flag against the result, and the fixed bits of the status byte. The arithmetic values themselves are only shown by the bench's operand patterns. These include nibble and byte overflow, borrow chains through subtract with borrow, and carry kept across increment and decrement. The same holds for the truth table of the condition codes and for reset arriving in the middle of a run.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBB = 4'd3;
  localparam logic [3:0] OP_INC = 4'd4;
  localparam logic [3:0] OP_DEC = 4'd5;
  localparam logic [3:0] OP_AND = 4'd6;
  localparam logic [3:0] OP_XOR = 4'd7;
  localparam logic [3:0] OP_OR  = 4'd8;
  localparam logic [3:0] OP_CMP = 4'd9;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;
endpackage

// File: rtl/alu8_nib_adder.sv
module alu8_nib_adder #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              half_cy
);
  localparam int N_NIB = DATA_W / NIB_W;

  logic [N_NIB:0] chain;
  assign chain[0] = cin;

  for (genvar g = 0; g < N_NIB; g++) begin : g_nib
    logic [NIB_W:0] part;
    assign part = {1'b0, a[g*NIB_W +: NIB_W]} + {1'b0, b[g*NIB_W +: NIB_W]}
                + {{NIB_W{1'b0}}, chain[g]};
    assign sum[g*NIB_W +: NIB_W] = part[NIB_W-1:0];
    assign chain[g+1] = part[NIB_W];
  end

  assign cout    = chain[N_NIB];
  assign half_cy = chain[1];
endmodule

// File: rtl/alu8_flag_codec.sv
module alu8_flag_codec
  import alu8_pkg::*;
(
  input  flags_t     cur,
  input  logic [7:0] byte_in,
  output logic [7:0] byte_out,
  output flags_t     unpacked
);
  assign byte_out = {cur.s, cur.z, 1'b0, cur.ac, 1'b0, cur.p, 1'b1, cur.cy};

  assign unpacked.s  = byte_in[7];
  assign unpacked.z  = byte_in[6];
  assign unpacked.ac = byte_in[4];
  assign unpacked.p  = byte_in[2];
  assign unpacked.cy = byte_in[0];
endmodule

// File: rtl/alu8_cond_eval.sv
module alu8_cond_eval
  import alu8_pkg::*;
(
  input  flags_t     cur,
  input  logic [2:0] code,
  output logic       hit
);
  logic raw;
  always_comb begin
    case (code[2:1])
      2'd0:    raw = cur.z;
      2'd1:    raw = cur.cy;
      2'd2:    raw = cur.p;
      default: raw = cur.s;
    endcase
    hit = code[0] ? raw : ~raw;
  end
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic              flag_wr,
  input  logic              flag_ld,
  input  logic [7:0]        flag_byte_in,
  input  logic [2:0]        cond_code,
  output logic [DATA_W-1:0] result,
  output logic              acc_wr,
  output logic [4:0]        flags_nxt,
  output logic [4:0]        flags,
  output logic [7:0]        status_byte,
  output logic              cond_true
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  flags_t fq, fd, f_unp;
  logic [DATA_W-1:0] add_a, add_b, add_sum;
  logic add_inv, add_cin, add_cout, add_hc;

  always_comb begin
    add_a   = acc_in;
    add_b   = opnd_in;
    add_inv = 1'b0;
    add_cin = 1'b0;
    case (op_sel)
      OP_ADC:         add_cin = fq.cy;
      OP_SUB, OP_CMP: begin add_inv = 1'b1; add_cin = 1'b1;   end
      OP_SBB:         begin add_inv = 1'b1; add_cin = ~fq.cy; end
      OP_INC:         begin add_a = opnd_in; add_b = ONE; end
      OP_DEC:         begin add_a = opnd_in; add_b = ONE; add_inv = 1'b1; add_cin = 1'b1; end
      default: ;
    endcase
  end

  alu8_nib_adder #(.DATA_W(DATA_W), .NIB_W(NIB_W)) i_add (
    .a(add_a), .b(add_inv ? ~add_b : add_b), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .half_cy(add_hc)
  );

  logic known;
  always_comb begin
    known  = 1'b1;
    result = add_sum;
    fd     = fq;
    case (op_sel)
      OP_ADD, OP_ADC: begin fd.cy = add_cout;  fd.ac = add_hc; end
      OP_SUB, OP_SBB, OP_CMP: begin fd.cy = ~add_cout; fd.ac = add_hc; end
      OP_INC, OP_DEC: fd.ac = add_hc;
      OP_AND: begin result = acc_in & opnd_in; fd.cy = 1'b0; fd.ac = 1'b0; end
      OP_XOR: begin result = acc_in ^ opnd_in; fd.cy = 1'b0; fd.ac = 1'b0; end
      OP_OR:  begin result = acc_in | opnd_in; fd.cy = 1'b0; fd.ac = 1'b0; end
      default: begin known = 1'b0; result = '0; end
    endcase
    if (known) begin
      fd.s = result[DATA_W-1];
      fd.z = (result == '0);
      fd.p = ~^result;
    end
  end

  assign acc_wr = known && (op_sel != OP_CMP);

  alu8_flag_codec i_codec (
    .cur(fq), .byte_in(flag_byte_in), .byte_out(status_byte), .unpacked(f_unp)
  );

  alu8_cond_eval i_cond (.cur(fq), .code(cond_code), .hit(cond_true));

  flags_t f_next;
  always_comb begin
    f_next = fq;
    if (flag_ld)      f_next = f_unp;
    else if (flag_wr) f_next = fd;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) fq <= '0;
    else          fq <= f_next;
  end

  assign flags     = fq;
  assign flags_nxt = fd;
endmodule

// File: rtl/alu8_flag_chk.sv
module alu8_flag_chk
  import alu8_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op_sel,
  input logic       flag_wr,
  input logic       flag_ld,
  input logic [7:0] flag_byte_in,
  input logic [7:0] result,
  input logic [4:0] flags,
  input logic [7:0] status_byte
);
  // R8 R12
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld |=> flags == {$past(flag_byte_in[7]), $past(flag_byte_in[6]),
                          $past(flag_byte_in[4]), $past(flag_byte_in[2]),
                          $past(flag_byte_in[0])});

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_ld && !flag_wr) |=> $stable(flags));

  // R5
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_ld && (op_sel == OP_AND || op_sel == OP_XOR || op_sel == OP_OR))
    |=> (flags[2] == 1'b0 && flags[0] == 1'b0));

  // R6
  incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_ld && (op_sel == OP_INC || op_sel == OP_DEC))
    |=> flags[0] == $past(flags[0]));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_ld && op_sel <= OP_CMP) |=> flags[3] == ($past(result) == 8'h00));

  // R11
  status_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[1] && !status_byte[3] && !status_byte[5]
    && status_byte[0] == flags[0] && status_byte[7] == flags[4]);
endmodule

bind alu8_flag_unit alu8_flag_chk i_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .flag_wr(flag_wr), .flag_ld(flag_ld),
  .flag_byte_in(flag_byte_in), .result(result), .flags(flags), .status_byte(status_byte)
);

// File: tb/test_alu8_flag_unit.sv
`timescale 1ns/1ps
module test_alu8_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op_sel;
  logic [7:0] acc_in, opnd_in, flag_byte_in;
  logic       flag_wr, flag_ld;
  logic [2:0] cond_code;
  logic [7:0] result, status_byte;
  logic       acc_wr, cond_true;
  logic [4:0] flags_nxt, flags;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  alu8_flag_unit i_alu8_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in),
    .flag_wr(flag_wr), .flag_ld(flag_ld), .flag_byte_in(flag_byte_in),
    .cond_code(cond_code), .result(result), .acc_wr(acc_wr), .flags_nxt(flags_nxt),
    .flags(flags), .status_byte(status_byte), .cond_true(cond_true)
  );

  // {op, acc, opnd, preload status byte}
  localparam logic [27:0] VEC [0:15] = '{
    28'h0_0F_01_00, 28'h0_FF_01_00, 28'h1_10_20_01, 28'h1_FF_00_01,
    28'h2_05_07_00, 28'h2_3C_3C_00, 28'h3_10_01_01, 28'h3_00_00_01,
    28'h9_40_41_00, 28'h4_00_FF_01, 28'h4_00_0F_00, 28'h5_00_00_00,
    28'h5_00_10_01, 28'h6_F0_3C_11, 28'h7_AA_AA_00, 28'h8_80_01_11
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] unpack(logic [7:0] b);
    return {b[7], b[6], b[4], b[2], b[0]};
  endfunction

  // expected {result, flags} from the requirements
  function automatic logic [12:0] model(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [4:0] f);
    logic [8:0] t;
    logic [7:0] r;
    logic cy, ac;
    cy = f[0]; ac = f[2]; r = 8'h00;
    case (op)
      4'd0, 4'd1: begin
        logic ci; ci = (op == 4'd1) ? f[0] : 1'b0;
        t = {1'b0, a} + {1'b0, b} + {8'd0, ci};
        r = t[7:0]; cy = t[8];
        ac = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, ci}) > 5'd15;
      end
      4'd2, 4'd3, 4'd9: begin
        logic br; br = (op == 4'd3) ? f[0] : 1'b0;
        t = {1'b0, a} - {1'b0, b} - {8'd0, br};
        r = t[7:0]; cy = t[8];
        ac = {1'b0, a[3:0]} >= ({1'b0, b[3:0]} + {4'd0, br});
      end
      4'd4: begin r = b + 8'd1; ac = (b[3:0] == 4'hF); end
      4'd5: begin r = b - 8'd1; ac = (b[3:0] != 4'h0); end
      4'd6: begin r = a & b; cy = 0; ac = 0; end
      4'd7: begin r = a ^ b; cy = 0; ac = 0; end
      4'd8: begin r = a | b; cy = 0; ac = 0; end
      default: ;
    endcase
    return {r, r[7], (r == 8'h00), ac, ~^r, cy};
  endfunction

  task automatic load_flags(logic [7:0] b);
    @(negedge clk);
    flag_ld = 1'b1; flag_byte_in = b; flag_wr = 1'b0;
    @(negedge clk);
    flag_ld = 1'b0;
  endtask

  task automatic check_conds(logic [4:0] f);
    logic [7:0] exp;
    exp = {f[4], ~f[4], f[1], ~f[1], f[0], ~f[0], f[3], ~f[3]};
    for (int c = 0; c < 8; c++) begin
      cond_code = 3'(c);
      #1;
      chk($sformatf("R13 cond %0d", c), cond_true, exp[c]);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_sel = 4'd0; acc_in = 0; opnd_in = 0; flag_wr = 0; flag_ld = 0;
    flag_byte_in = 0; cond_code = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset flags", flags, 5'h00);
    chk("R11 reset status byte", status_byte, 8'h02);
    check_conds(5'h00);

    for (int i = 0; i < 16; i++) begin
      logic [3:0] op; logic [7:0] a, b, pre; logic [12:0] exp; logic [4:0] pf;
      {op, a, b, pre} = VEC[i];
      pf = unpack(pre);
      load_flags(pre);
      op_sel = op; acc_in = a; opnd_in = b; flag_wr = 1'b1;
      exp = model(op, a, b, pf);
      #1;
      chk($sformatf("R1 R2 R3 R6 result vec %0d", i), result, exp[12:5]);
      chk($sformatf("R7 acc_wr vec %0d", i), acc_wr, (op != 4'd9));
      @(negedge clk);
      flag_wr = 1'b0;
      #1;
      chk($sformatf("R4 R5 R8 flags vec %0d", i), flags, exp[4:0]);
    end

    // R12 unpack: all defined bits, then only the ignored bits
    load_flags(8'hFF); #1;
    chk("R12 unpack FF", flags, 5'h1F);
    chk("R11 status of all-set flags", status_byte, 8'hD7);
    check_conds(5'h1F);
    load_flags(8'h2A); #1;
    chk("R12 ignored bits", flags, 5'h00);

    // R9 reserved opcode keeps flags, gives 0, no accumulator write
    load_flags(8'hD7);
    op_sel = 4'hC; acc_in = 8'h12; opnd_in = 8'h34; flag_wr = 1'b1; #1;
    chk("R9 reserved result", result, 8'h00);
    chk("R7 reserved acc_wr", acc_wr, 1'b0);
    @(negedge clk); flag_wr = 1'b0; #1;
    chk("R9 reserved keeps flags", flags, 5'h1F);

    // R8 load wins over write; hold without strobes
    op_sel = 4'd0; acc_in = 8'hFF; opnd_in = 8'hFF; flag_wr = 1'b1; flag_ld = 1'b1;
    flag_byte_in = 8'h01;
    @(negedge clk); flag_wr = 1'b0; flag_ld = 1'b0; #1;
    chk("R8 load priority", flags, 5'h01);
    op_sel = 4'd6; acc_in = 8'h00;
    @(negedge clk); #1;
    chk("R8 hold without strobe", flags, 5'h01);

    // R10 reset in the middle of a run acts at once
    load_flags(8'hFF);
    rst_n = 1'b0; #1;
    chk("R10 async reset", flags, 5'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk); #1;
    chk("R10 flags after release", status_byte, 8'h02);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule